// File: doc/BRIEF.md
# Serially configured clock fan-out enable controller

This block distributes one reference clock to thirteen gated outputs. Each output can be switched on or off through a write-only two-wire serial slave that follows the SMBus block-write framing. The serial lines are oversampled by a fast system clock. A start condition opens a frame. The first byte must carry the slave address with the write bit clear. After it come two bytes that only hold the frame's byte positions, and then seven data bytes. Three of the data bytes carry the enable bits for the outputs.

Each output enable resets to active. An enable bit changes as soon as the data byte that carries it has fully arrived. A disabled output is held low. The gating flop for each output is clocked on the falling edge of the reference clock, so an output is switched only while that clock is low. No output pulse is ever shortened.

Top module: `clkout_gate_cfg`

## Requirements
- R1: While reset is asserted and after it is released, all thirteen enables read 1, every output follows the reference clock, and the acknowledge pull-down is inactive.
- R2: A frame whose first byte is 0xD2 (7-bit address 0x69 followed by a write bit of 0) is acknowledged on every one of its ten bytes. A frame with any other first byte, including 0xD3, receives no acknowledge and changes no enable.
- R3: A frame is ordered as address, command, count, then data bytes 0 to 6. The command and count values have no effect on the enables, but both bytes are acknowledged.
- R4: Serial bits are taken most significant bit first. Bit 7 is the first bit clocked in after the start or after the previous acknowledge.
- R5: Data byte 0 sets output 5 from bit 7, output 4 from bit 6, and outputs 3..0 from bits 3..0. Bits 5 and 4 have no effect.
- R6: Data byte 1 sets outputs 11..8 from bits 7..4 and outputs 7..6 from bits 1..0. Bits 3 and 2 have no effect.
- R7: Data byte 2 sets output 12 from bit 6. Its other bits, and all of data bytes 3 to 6, have no effect.
- R8: An output whose enable is 1 equals the reference clock. An output whose enable is 0 is held low. The gating of an output changes only while the reference clock is low.
- R9: For an accepted byte, the block pulls the data line low for the whole ninth clock pulse. The pull-down changes only while the serial clock is low.
- R10: Each data byte is committed when its eighth bit completes. A frame stopped after data byte 0 updates only the outputs that byte controls.
- R11: A stop or a repeated start in the middle of a byte discards that byte and changes no enable. A repeated start opens a new frame.
- R12: Bytes after the tenth byte of a frame are not acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Oversampling clock for the serial interface and the enable registers |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| refClk | input | 1 | Reference clock that is fanned out |
| sdaPullLow | output | 1 | 1 pulls the serial data line low (acknowledge) |
| clkOut | output | 13 | Gated copies of the reference clock |
| enableState | output | 13 | Current enable of each output (1 = active) |

## Verification
If the byte counter or the bit counter slips, the fault appears at the ports within one byte time. The acknowledge pulse either goes missing or lands in the wrong clock slot, and the enable nibbles show up on the wrong outputs. A bad address latch produces acknowledges on a foreign frame, or none on a matching one, starting from the first byte. A mis-timed gating flop shows up within one reference clock period, either as an output that is high while the reference is low or as an enabled output that stays low.

// File: rtl/clkout_gate_cfg_pkg.sv
`timescale 1ns/1ps
package clkout_gate_cfg_pkg;
  localparam int NUM_OUT       = 13;
  localparam int BITS_PER_BYTE = 8;
  localparam int FRAME_BYTES   = 10;
  localparam int FIRST_DATA    = 3;
  localparam int USED_DATA     = 3;
  localparam int SEL_W         = $clog2(USED_DATA);
  localparam int IDX_W         = $clog2(FRAME_BYTES + 1);
  localparam int BIT_W         = $clog2(BITS_PER_BYTE + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_ACK} busState_t;

  typedef struct packed {
    logic             shiftEn;
    logic             commitEn;
    logic [SEL_W-1:0] commitSel;
  } ctlStb_t;

  // which used data byte (0..2) carries the enable of an output
  function automatic int outSrcByte(input int o);
    if (o <= 5) return 0;
    else if (o <= 11) return 1;
    else return 2;
  endfunction

  // bit position inside that byte
  function automatic int outSrcBit(input int o);
    if (o <= 3) return o;
    else if (o == 4) return 6;
    else if (o == 5) return 7;
    else if (o <= 7) return o - 6;
    else if (o <= 11) return o - 4;
    else return 6;
  endfunction
endpackage

// File: rtl/clkout_gate_sync.sv
`timescale 1ns/1ps
module clkout_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic              sclPrev;
  logic              sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  always_comb begin
    sclLvl   = sclPipe[STAGES-1];
    sdaLvl   = sdaPipe[STAGES-1];
    sclRise  = sclLvl & ~sclPrev;
    sclFall  = ~sclLvl & sclPrev;
    startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
    stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  end
endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
  import clkout_gate_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic             addrHit,
  output ctlStb_t          ctlStb,
  output logic             ackDrv,
  output logic [IDX_W-1:0] byteIdx,
  output logic             addrOk
);
  busState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic             byteEnd;
  logic             inData;
  logic             ackNext;

  always_comb begin
    byteEnd = (state == ST_BITS) && sclFall && (bitCnt == BIT_W'(BITS_PER_BYTE));
    inData  = (byteIdx >= IDX_W'(FIRST_DATA)) &&
              (byteIdx <  IDX_W'(FIRST_DATA + USED_DATA));
    ackNext = (byteIdx == '0) ? addrHit
                              : (addrOk && (byteIdx < IDX_W'(FRAME_BYTES)));
    ctlStb.shiftEn   = (state == ST_BITS) && sclRise &&
                       (bitCnt < BIT_W'(BITS_PER_BYTE));
    ctlStb.commitEn  = byteEnd && addrOk && inData;
    ctlStb.commitSel = SEL_W'(byteIdx - IDX_W'(FIRST_DATA));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteIdx <= '0;
      addrOk  <= 1'b0;
      ackDrv  <= 1'b0;
    end else if (startDet) begin
      state   <= ST_BITS;
      bitCnt  <= '0;
      byteIdx <= '0;
      addrOk  <= 1'b0;
      ackDrv  <= 1'b0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      addrOk  <= 1'b0;
      ackDrv  <= 1'b0;
    end else begin
      case (state)
        ST_BITS: begin
          if (ctlStb.shiftEn) bitCnt <= bitCnt + 1'b1;
          if (byteEnd) begin
            state  <= ST_ACK;
            ackDrv <= ackNext;
            if (byteIdx == '0) addrOk <= addrHit;
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state  <= ST_BITS;
            ackDrv <= 1'b0;
            bitCnt <= '0;
            if (byteIdx != IDX_W'(FRAME_BYTES)) byteIdx <= byteIdx + 1'b1;
          end
        end
        default: begin
          bitCnt <= '0;
          ackDrv <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/clkout_gate_dp.sv
`timescale 1ns/1ps
module clkout_gate_dp
  import clkout_gate_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaLvl,
  input  ctlStb_t            ctlStb,
  output logic               addrHit,
  output logic [NUM_OUT-1:0] enReg
);
  logic [BITS_PER_BYTE-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctlStb.shiftEn) shiftReg <= {shiftReg[BITS_PER_BYTE-2:0], sdaLvl};
  end

  assign addrHit = (shiftReg == {SLAVE_ADDR, 1'b0});

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_en
    localparam int SRC_BYTE = outSrcByte(o);
    localparam int SRC_BIT  = outSrcBit(o);
    logic enBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) enBit <= 1'b1;
      else if (ctlStb.commitEn && (ctlStb.commitSel == SEL_W'(SRC_BYTE)))
        enBit <= shiftReg[SRC_BIT];
    end
    assign enReg[o] = enBit;
  end
endmodule

// File: rtl/clkout_gate_out.sv
`timescale 1ns/1ps
module clkout_gate_out
  import clkout_gate_cfg_pkg::*;
(
  input  logic               refClk,
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] enReg,
  output logic [NUM_OUT-1:0] gateEn,
  output logic [NUM_OUT-1:0] clkOut
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_gate
    logic held;
    always_ff @(negedge refClk or negedge rstN) begin
      if (!rstN) held <= 1'b1;
      else held <= enReg[o];
    end
    assign gateEn[o] = held;
    assign clkOut[o] = refClk & held;
  end
endmodule

// File: rtl/clkout_gate_cfg.sv
`timescale 1ns/1ps
module clkout_gate_cfg
  import clkout_gate_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               sysClk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               refClk,
  output logic               sdaPullLow,
  output logic [NUM_OUT-1:0] clkOut,
  output logic [NUM_OUT-1:0] enableState
);
  logic             sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic             addrHit, addrOk;
  logic [IDX_W-1:0] byteIdx;
  logic [NUM_OUT-1:0] gateEn;
  ctlStb_t          ctlStb;

  clkout_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(sysClk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  clkout_gate_ctrl u_ctrl (
    .clk(sysClk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .addrHit(addrHit),
    .ctlStb(ctlStb), .ackDrv(sdaPullLow), .byteIdx(byteIdx), .addrOk(addrOk)
  );

  clkout_gate_dp #(.SLAVE_ADDR(SLAVE_ADDR)) u_dp (
    .clk(sysClk), .rstN(rstN), .sdaLvl(sdaLvl), .ctlStb(ctlStb),
    .addrHit(addrHit), .enReg(enableState)
  );

  clkout_gate_out u_out (
    .refClk(refClk), .rstN(rstN), .enReg(enableState),
    .gateEn(gateEn), .clkOut(clkOut)
  );
endmodule

// File: rtl/clkout_gate_cfg_chk.sv
`timescale 1ns/1ps
module clkout_gate_cfg_chk
  import clkout_gate_cfg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               sclLvl,
  input logic               refClk,
  input logic               sdaPullLow,
  input logic [NUM_OUT-1:0] gateEn,
  input logic [NUM_OUT-1:0] enReg,
  input ctlStb_t            ctlStb,
  input logic               addrOk,
  input logic               startDet,
  input logic [IDX_W-1:0]   byteIdx
);
  a_r9_ack_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl);

  a_r8_gate_moves_ref_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gateEn) |-> !refClk);

  a_r10_en_moves_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enReg) |-> $past(ctlStb.commitEn));

  a_r2_commit_needs_addr: assert property (@(posedge clk) disable iff (!rstN)
    ctlStb.commitEn |-> addrOk);

  a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (byteIdx == '0) && !sdaPullLow);

  a_r12_ack_within_frame: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> (byteIdx < IDX_W'(FRAME_BYTES)));
endmodule

bind clkout_gate_cfg clkout_gate_cfg_chk u_chk (
  .clk(sysClk), .rstN(rstN), .sclLvl(sclLvl), .refClk(refClk),
  .sdaPullLow(sdaPullLow), .gateEn(gateEn), .enReg(enableState),
  .ctlStb(ctlStb), .addrOk(addrOk), .startDet(startDet), .byteIdx(byteIdx)
);

// File: tb/clkout_gate_cfg_bench.sv
`timescale 1ns/1ps
module clkout_gate_cfg_bench;
  logic        sysClk = 1'b0;
  logic        refClk = 1'b0;
  logic        rstN;
  logic        sclDrv, sdaDrv;
  logic        sdaPullLow;
  logic [12:0] clkOut, enableState;
  logic        sdaBus;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  assign sdaBus = sdaDrv & ~sdaPullLow;

  clkout_gate_cfg u_clkout_gate_cfg (
    .sysClk(sysClk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .refClk(refClk), .sdaPullLow(sdaPullLow), .clkOut(clkOut),
    .enableState(enableState)
  );

  always #2 sysClk = ~sysClk;
  initial begin
    #1;
    forever #20 refClk = ~refClk;
  end

  // {addr, data0, data1, data2, ack expected, enables expected}
  localparam logic [45:0] VEC [8] = '{
    {8'hD2, 8'h00, 8'h00, 8'h00, 1'b1, 13'h0000},
    {8'hD2, 8'hFF, 8'hFF, 8'hFF, 1'b1, 13'h1FFF},
    {8'hD2, 8'h30, 8'h0C, 8'hBF, 1'b1, 13'h0000},
    {8'hD2, 8'h80, 8'h01, 8'h40, 1'b1, 13'h1060},
    {8'hD4, 8'h00, 8'h00, 8'h00, 1'b0, 13'h1060},
    {8'hD3, 8'hFF, 8'hFF, 8'hFF, 1'b0, 13'h1060},
    {8'hD2, 8'h41, 8'h90, 8'h00, 1'b1, 13'h0911},
    {8'hD2, 8'h0A, 8'h22, 8'h40, 1'b1, 13'h128A}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic sendStart();
    tick(8); sdaDrv = 1'b1;
    tick(8); sclDrv = 1'b1;
    tick(16); sdaDrv = 1'b0;
    tick(16); sclDrv = 1'b0;
  endtask

  task automatic sendStop();
    tick(8); sdaDrv = 1'b0;
    tick(8); sclDrv = 1'b1;
    tick(16); sdaDrv = 1'b1;
    tick(16);
  endtask

  task automatic sendBit(input logic b);
    tick(8); sdaDrv = b;
    tick(8); sclDrv = 1'b1;
    tick(16); sclDrv = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    tick(8); sdaDrv = 1'b1;
    tick(8); sclDrv = 1'b1;
    tick(8); ack = sdaPullLow;
    tick(8); sclDrv = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] addr, input logic [7:0] cmd,
                           input logic [7:0] cnt, input logic [7:0] d0,
                           input logic [7:0] d1, input logic [7:0] d2,
                           output int acks);
    logic a;
    acks = 0;
    sendStart();
    sendByte(addr, a); acks += int'(a);
    sendByte(cmd, a);  acks += int'(a);
    sendByte(cnt, a);  acks += int'(a);
    sendByte(d0, a);   acks += int'(a);
    sendByte(d1, a);   acks += int'(a);
    sendByte(d2, a);   acks += int'(a);
    for (int k = 0; k < 4; k++) begin
      sendByte(8'hFF, a); acks += int'(a);
    end
    sendStop();
  endtask

  task automatic checkGate(input logic [12:0] exp, input string tag);
    repeat (3) @(posedge refClk);
    #7 chk(tag, 32'(clkOut), 32'(exp));
    @(negedge refClk);
    #7 chk(tag, 32'(clkOut), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int acks;
    logic a;
    rstN = 1'b0; sclDrv = 1'b1; sdaDrv = 1'b1;
    tick(10);
    chk("R1 enables in reset", 32'(enableState), 32'h1FFF);
    rstN = 1'b1;
    tick(10);
    chk("R1 enables after reset", 32'(enableState), 32'h1FFF);
    chk("R1 no ack after reset", 32'(sdaPullLow), 32'h0);
    checkGate(13'h1FFF, "R1 R8 outputs follow ref after reset");

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [45:0] e;
      e = VEC[v];
      sendFrame(e[45:38], 8'hA5 ^ 8'(v), 8'(7 * v), e[37:30], e[29:22], e[21:14], acks);
      chk($sformatf("R2 R3 acks vector %0d", v), 32'(acks), e[13] ? 32'd10 : 32'd0);
      chk($sformatf("R4 R5 R6 R7 enables vector %0d", v), 32'(enableState), 32'(e[12:0]));
    end
    checkGate(13'h128A, "R8 gated outputs");

    // R10: stop after data byte 0
    sendStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h03, a);
    sendByte(8'hFF, a);
    sendStop();
    chk("R10 partial frame byte 0 only", 32'(enableState), 32'h12BF);

    // R11: stop in middle of data byte 1
    sendStart();
    sendByte(8'hD2, a); sendByte(8'h11, a); sendByte(8'h22, a);
    sendByte(8'h00, a);
    for (int k = 0; k < 4; k++) sendBit(1'b0);
    sendStop();
    chk("R11 stop mid-byte", 32'(enableState), 32'h1280);

    // R11: repeated start mid-byte then a new full frame
    sendStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    for (int k = 0; k < 3; k++) sendBit(1'b1);
    chk("R11 repeated start mid-byte no change", 32'(enableState), 32'h1280);
    sendStart();
    sendByte(8'hD2, a);
    chk("R11 new frame address acked", 32'(a), 32'h1);
    sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h0F, a); sendByte(8'h03, a); sendByte(8'h00, a);
    for (int k = 0; k < 4; k++) sendByte(8'h00, a);
    sendStop();
    chk("R11 frame after repeated start", 32'(enableState), 32'h00CF);
    checkGate(13'h00CF, "R8 gating after repeated start");

    // R12: eleventh byte
    sendStart();
    sendByte(8'hD2, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'hFF, a); sendByte(8'hFF, a); sendByte(8'h40, a);
    for (int k = 0; k < 3; k++) sendByte(8'h00, a);
    sendByte(8'h00, a);
    chk("R9 tenth byte acked", 32'(a), 32'h1);
    sendByte(8'h00, a);
    chk("R12 eleventh byte not acked", 32'(a), 32'h0);
    sendStop();
    chk("R12 eleventh byte ignored", 32'(enableState), 32'h1FFF);

    // R9: ack released after ninth pulse
    sendStart();
    sendByte(8'hD2, a);
    chk("R9 address ack", 32'(a), 32'h1);
    tick(8);
    chk("R9 ack released", 32'(sdaPullLow), 32'h0);
    sendStop();

    // R1: reset mid-state
    sendFrame(8'hD2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, acks);
    chk("R8 all disabled", 32'(enableState), 32'h0000);
    checkGate(13'h0000, "R8 disabled outputs low");
    rstN = 1'b0;
    tick(4);
    chk("R1 reset restores enables", 32'(enableState), 32'h1FFF);
    chk("R1 reset releases ack", 32'(sdaPullLow), 32'h0);
    rstN = 1'b1;
    tick(4);
    checkGate(13'h1FFF, "R1 outputs after second reset");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule